// File: doc/BRIEF.md
# Tracking Set-Speed Memory

This block holds a set speed as an unsigned binary count and captures a new value by walking the count towards a measured speed. It does not load the measured value in one step. A store request starts a capture. From then on the block compares the held count with the live speed input. On each cycle where the update enable is high, it moves the count one step up or down towards that input. When the two are equal, the capture ends and the count is held.

The held count is presented as a parallel word that a digital-to-analog ladder elsewhere turns into a memory voltage. A busy flag marks a capture in progress. An equal flag reports a live match between the held count and the input. A valid flag rises with the first completed capture after reset.

Top module: `spdmem_tracker`

## Requirements
- R1: After reset the held count is 0, and busy and valid are both 0.
- R2: A store request sampled high on a clock edge makes busy 1 from that edge on. The count does not move on that edge.
- R3: While busy, each edge with the update enable high raises the count by exactly 1 when it is below the speed input.
- R4: While busy, each edge with the update enable high lowers the count by exactly 1 when it is above the speed input.
- R5: While the update enable is low, the count does not change, even when busy.
- R6: When busy, the count equals the input and no store request is present, busy falls on the next edge and valid becomes 1. A capture therefore keeps busy high for |start − target| + 1 cycles when the enable is held high.
- R7: While not busy, the count holds regardless of the speed input and the update enable.
- R8: A store request during a capture keeps busy high. The capture then ends at whatever value the speed input has at that point, including when the direction reverses.
- R9: The equal output is 1 exactly when the held count equals the speed input, in the same cycle.
- R10: The count never wraps. It stays within 0 to 2^W−1, so a capture to 511 ends at 511 and a capture to 0 ends at 0 (W = 9).
- R11: Once valid is 1, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_in | input | W | Measured speed value, unsigned |
| store_req | input | 1 | Starts or retargets a capture |
| step_en | input | 1 | Update enable; allows one count step |
| mem_out | output | W | Held count, drives the ladder |
| busy | output | 1 | Capture in progress |
| equal | output | 1 | Held count equals speed input |
| mem_valid | output | 1 | At least one capture completed since reset |

## Verification
The assertions assume that the speed input and the request are synchronous to the clock, and that the request can be held for any number of cycles. The step-direction properties take the speed input as the one sampled on the same edge as the step. The bench changes inputs only on falling edges, so each rising edge sees one stable set of values. The retarget scenario changes the speed input in the same cycle as the new request, so that every property sees a consistent target.

// File: rtl/spdmem_pkg.sv
package spdmem_pkg;
   typedef enum logic [1:0] {
      DIR_HOLD = 2'b00,
      DIR_UP   = 2'b01,
      DIR_DOWN = 2'b10
   } step_dir_e;
endpackage

// File: rtl/spdmem_cmp.sv
module spdmem_cmp
   import spdmem_pkg::*;
#(
   parameter int W = 9
) (
   input  logic [W-1:0] held,
   input  logic [W-1:0] target,
   output step_dir_e    dir,
   output logic         eq
);
   always_comb begin
      eq = (held == target);
      if (held < target)      dir = DIR_UP;
      else if (held > target) dir = DIR_DOWN;
      else                    dir = DIR_HOLD;
   end
endmodule

// File: rtl/spdmem_counter.sv
module spdmem_counter
   import spdmem_pkg::*;
#(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         advance,
   input  step_dir_e    dir,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = {W{1'b1}};
   localparam logic [W-1:0] BOT = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= BOT;
      end else if (advance) begin
         if (dir == DIR_UP && count != TOP)
            count <= count + 1'b1;
         else if (dir == DIR_DOWN && count != BOT)
            count <= count - 1'b1;
      end
   end

   a_r5_no_step_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(count));
   a_r10_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
      count == TOP |=> count != BOT);
   a_r10_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
      count == BOT |=> count != TOP);
endmodule

// File: rtl/spdmem_ctrl.sv
module spdmem_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic store_req,
   input  logic eq,
   output logic busy,
   output logic valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         valid <= 1'b0;
      end else if (store_req) begin
         busy <= 1'b1;
      end else if (busy && eq) begin
         busy  <= 1'b0;
         valid <= 1'b1;
      end
   end

   a_r2_req_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |=> busy);
   a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      busy && eq && !store_req |=> !busy && valid);
   a_r11_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> valid);
endmodule

// File: rtl/spdmem_tracker.sv
module spdmem_tracker
   import spdmem_pkg::*;
#(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] speed_in,
   input  logic         store_req,
   input  logic         step_en,
   output logic [W-1:0] mem_out,
   output logic         busy,
   output logic         equal,
   output logic         mem_valid
);
   generate
      if (W < 2 || W > 24) begin : g_bad_width
         $error("spdmem_tracker: W must lie in 2..24");
      end
   endgenerate

   step_dir_e dir;
   logic      eq;
   logic      advance;

   assign advance = busy & step_en;
   assign equal   = eq;

   spdmem_cmp #(.W(W)) u_cmp (
      .held(mem_out), .target(speed_in), .dir(dir), .eq(eq)
   );

   spdmem_counter #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .advance(advance), .dir(dir), .count(mem_out)
   );

   spdmem_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .store_req(store_req), .eq(eq),
      .busy(busy), .valid(mem_valid)
   );

   a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      busy && step_en && (mem_out < speed_in) |=> mem_out == W'($past(mem_out) + 1'b1));
   a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      busy && step_en && (mem_out > speed_in) |=> mem_out == W'($past(mem_out) - 1'b1));
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(mem_out));
endmodule

// File: tb/spdmem_tracker_bench.sv
module spdmem_tracker_bench;
   localparam int W = 9;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] speed_in = '0;
   logic         store_req = 1'b0;
   logic         step_en = 1'b0;
   logic [W-1:0] mem_out;
   logic         busy, equal, mem_valid;
   int           n_chk = 0;
   int           n_bad = 0;
   bit           done = 1'b0;

   always #2.5 clk = ~clk;

   spdmem_tracker #(.W(W)) u_spdmem_tracker (
      .clk(clk), .rst_n(rst_n), .speed_in(speed_in), .store_req(store_req),
      .step_en(step_en), .mem_out(mem_out), .busy(busy), .equal(equal),
      .mem_valid(mem_valid)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic test_reset();
      check("R1 mem", int'(mem_out), 0);
      check("R1 busy", int'(busy), 0);
      check("R1 valid", int'(mem_valid), 0);
   endtask

   // full capture with enable held high; checks each step and the busy length
   task automatic test_capture(int target);
      int start = int'(mem_out);
      int diff = (target > start) ? target - start : start - target;
      int seen = 0;
      int prev;
      bit step_ok = 1'b1;
      speed_in = W'(target); store_req = 1'b1; step_en = 1'b1;
      @(negedge clk);
      store_req = 1'b0;
      check("R2 busy after request", int'(busy), 1);
      check("R2 no move on request edge", int'(mem_out), start);
      prev = int'(mem_out);
      while (busy && seen < 2000) begin
         seen++;
         @(negedge clk);
         if (busy || int'(mem_out) != prev) begin
            if (target > prev && int'(mem_out) != prev + 1) step_ok = 1'b0;
            if (target < prev && int'(mem_out) != prev - 1) step_ok = 1'b0;
         end
         prev = int'(mem_out);
      end
      check(target >= start ? "R3 unit steps up" : "R4 unit steps down", int'(step_ok), 1);
      check("R6 busy length", seen, diff + 1);
      check("R10 final value", int'(mem_out), target);
      check("R6 valid after done", int'(mem_valid), 1);
      check("R9 equal at end", int'(equal), 1);
      step_en = 1'b0;
   endtask

   task automatic test_gate();
      int start = int'(mem_out);
      speed_in = W'(start + 20); store_req = 1'b1; step_en = 1'b0;
      @(negedge clk);
      store_req = 1'b0;
      repeat (6) @(negedge clk);
      check("R5 no step with enable low", int'(mem_out), start);
      check("R5 still busy", int'(busy), 1);
      step_en = 1'b1;
      @(negedge clk);
      check("R3 step once enabled", int'(mem_out), start + 1);
      step_en = 1'b0;
      @(negedge clk);
      check("R5 hold again", int'(mem_out), start + 1);
      step_en = 1'b1;
      repeat (40) @(negedge clk);
      check("R6 finished after gating", int'(mem_out), start + 20);
      check("R6 busy low", int'(busy), 0);
      step_en = 1'b0;
   endtask

   task automatic test_idle_hold();
      int start = int'(mem_out);
      for (int i = 0; i < 8; i++) begin
         speed_in = W'(i * 61);
         step_en = i[0];
         #0.1;
         check("R9 equal live", int'(equal), int'(mem_out == W'(i * 61)));
         @(negedge clk);
         check("R7 idle hold", int'(mem_out), start);
      end
      check("R7 not busy", int'(busy), 0);
      check("R11 valid kept", int'(mem_valid), 1);
      step_en = 1'b0;
   endtask

   task automatic test_retarget();
      int start = int'(mem_out);
      speed_in = W'(start + 30); store_req = 1'b1; step_en = 1'b1;
      @(negedge clk);
      store_req = 1'b0;
      repeat (10) @(negedge clk);
      check("R3 partway up", int'(mem_out), start + 10);
      speed_in = W'(start + 4); store_req = 1'b1;
      @(negedge clk);
      store_req = 1'b0;
      check("R8 busy kept on retarget", int'(busy), 1);
      repeat (12) @(negedge clk);
      check("R8 reached new target", int'(mem_out), start + 4);
      check("R8 done after retarget", int'(busy), 0);
      step_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_capture(5);
      test_capture(5);
      test_capture(0);
      test_gate();
      test_idle_hold();
      test_retarget();
      test_capture(500);
      test_capture(511);
      test_capture(0);
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule